// File: doc/BRIEF.md
# Interrupt Status Collector

This block gathers sixteen interrupt sources into one 16-bit read-only status word and drives a fast-interrupt request from a masked subset of them. Each source keeps its own rule. Some sources simply follow an active-low pin or an internal request line. Some are latched by a set event and cleared by a strobe on that source's end-of-interrupt location. Two pins are filtered by a slow sampler before they take effect. A watchdog bit flags a periodic tick that was not serviced before the next tick arrived.

Asynchronous pins pass through a two-flop synchronizer. The battery-sense condition and the media pin then pass through a deglitcher, which is clocked by a 16 kHz enable pulse. Software reads the word through a one-cycle read port. It clears latched bits with single-cycle end-of-interrupt strobes. A standby flag holds the battery-low bit and the watchdog bit inactive.

Top module: `irq_status_unit`

## Requirements
- R1: Status bits 0, 5, 6 and 7 read 1 while `fast_n`, `ext1_n`, `ext2_n` and `ext3_n` respectively are low, and 0 while they are high. They follow the pin two clock cycles after it changes. No end-of-interrupt strobe affects them.
- R2: Status bits 8 (`tmr1_req`), 9 (`tmr2_req`), 10 (`rtc_req`), 12 (`utx_req`), 13 (`urx_req`), 14 (`ums_req`) and 15 (`ssi_req`) equal their request inputs in the same cycle.
- R3: The battery-low condition is `pwr_absent` high with `batt_good` low. It reaches the filter output only after two consecutive `smp_en` samples see the condition. A condition seen on a single sample has no effect.
- R4: Bit 1 (battery-low) is set while the filtered condition holds. It stays set until an `eoi_batt` strobe arrives while the filtered condition is false. It reads 0 in the cycle after any cycle with `standby` high.
- R5: Bit 3 (media-changed) is set on a rising edge of the filtered `media_pin`. The filter uses the same two-sample rule as R3. The bit stays set after the pin falls, until `eoi_media`.
- R6: Bit 11 (tick) is set in the cycle after a `tick_en` pulse and is cleared by `eoi_tick`.
- R7: Bit 2 (watchdog) is set by a `tick_en` pulse that arrives while bit 11 is already set. It is cleared by `eoi_tick` and reads 0 after a cycle with `standby` high.
- R8: Bit 4 (codec) is set by `codec_req` and stays set after the request drops, until `eoi_codec`.
- R9: A set event and the matching end-of-interrupt strobe in the same cycle leave the bit set.
- R10: `fiq` is the OR of status bits 0 to 3, each ANDed with the matching bit of `fiq_mask`.
- R11: `rd_data` shows the status word in the cycle after `rd_en` is high, and reads 0 in the cycle after `rd_en` is low.
- R12: After reset, with every pin at its idle level, all status bits and `fiq` are 0. The idle levels are: the active-low pins high, `pwr_absent` low, `batt_good` high and `media_pin` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | 16 kHz sample enable for the deglitch filter |
| tick_en | input | 1 | One-cycle pulse on each periodic tick |
| standby | input | 1 | Standby flag; holds bits 1 and 2 inactive |
| fast_n | input | 1 | External fast interrupt pin, active low |
| ext1_n | input | 1 | External interrupt pin 1, active low |
| ext2_n | input | 1 | External interrupt pin 2, active low |
| ext3_n | input | 1 | External interrupt pin 3, active low |
| pwr_absent | input | 1 | High when no external supply is present |
| batt_good | input | 1 | Battery OK pin, low means battery low |
| media_pin | input | 1 | Media-change pin, acts on a rising edge |
| codec_req | input | 1 | Codec FIFO request |
| tmr1_req | input | 1 | Timer 1 underflow request |
| tmr2_req | input | 1 | Timer 2 underflow request |
| rtc_req | input | 1 | Real-time-clock match request |
| utx_req | input | 1 | UART transmit request |
| urx_req | input | 1 | UART receive request |
| ums_req | input | 1 | UART modem status request |
| ssi_req | input | 1 | Synchronous serial end-of-transfer request |
| rd_en | input | 1 | Status read strobe |
| eoi_batt | input | 1 | Battery-low end-of-interrupt strobe |
| eoi_tick | input | 1 | Tick and watchdog end-of-interrupt strobe |
| eoi_media | input | 1 | Media-changed end-of-interrupt strobe |
| eoi_codec | input | 1 | Codec end-of-interrupt strobe |
| fiq_mask | input | 4 | Enable mask for status bits 0 to 3 on `fiq` |
| rd_data | output | 16 | Status word, one cycle after `rd_en` |
| fiq | output | 1 | Fast interrupt request |

## Verification
A corrupted latch shows up in two places. It appears on the next read of `rd_data`. For bits 1 to 3 it also appears on `fiq` in the very same cycle, once the mask enables that bit. A deglitch filter stuck in the wrong state shows one `smp_en` period early or late, as a battery-low or media bit that sets on a single sample or never sets at all. A wrong watchdog or tick state is visible one cycle after the offending `tick_en` or `eoi_tick`.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W = 16;

  // status word bit positions (software decodes these)
  localparam int B_FAST  = 0;
  localparam int B_BATT  = 1;
  localparam int B_WDOG  = 2;
  localparam int B_MEDIA = 3;
  localparam int B_CODEC = 4;
  localparam int B_EXT1  = 5;
  localparam int B_EXT2  = 6;
  localparam int B_EXT3  = 7;
  localparam int B_TMR1  = 8;
  localparam int B_TMR2  = 9;
  localparam int B_RTC   = 10;
  localparam int B_TICK  = 11;
  localparam int B_UTX   = 12;
  localparam int B_URX   = 13;
  localparam int B_UMS   = 14;
  localparam int B_SSI   = 15;

  // synchronized pin vector layout
  localparam int NPIN  = 7;
  localparam int P_FAST = 0;
  localparam int P_EXT1 = 1;
  localparam int P_EXT2 = 2;
  localparam int P_EXT3 = 3;
  localparam int P_PWR  = 4;
  localparam int P_BOK  = 5;
  localparam int P_MED  = 6;
  localparam logic [NPIN-1:0] PIN_IDLE = 7'b0101111;

  // latched flag layout
  localparam int NLAT    = 5;
  localparam int L_BATT  = 0;
  localparam int L_WDOG  = 1;
  localparam int L_MEDIA = 2;
  localparam int L_CODEC = 3;
  localparam int L_TICK  = 4;

  // filtered signals
  localparam int NFLT  = 2;
  localparam int F_BATT = 0;
  localparam int F_MED  = 1;

  localparam int NFIQ = 4;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int              W   = 1,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/irq_deglitch.sv
module irq_deglitch #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] smp_q, smp_nxt;
  logic [W-1:0] out_q, out_nxt;
  logic [W-1:0] agree;

  always_comb begin
    agree   = ~(d ^ smp_q);
    smp_nxt = smp_q;
    out_nxt = out_q;
    if (smp_en) begin
      smp_nxt = d;
      out_nxt = (agree & d) | (~agree & out_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      out_q <= '0;
    end else begin
      smp_q <= smp_nxt;
      out_q <= out_nxt;
    end
  end

  assign q = out_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] kill,
  output logic [N-1:0] q
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_nxt;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (kill[i])      flag_nxt[i] = 1'b0;
      else if (set[i])  flag_nxt[i] = 1'b1;
      else if (clr[i])  flag_nxt[i] = 1'b0;
      else              flag_nxt[i] = flag_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_nxt[i];
    end
  end

  assign q = flag_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              tick_en,
  input  logic              standby,
  input  logic              fast_n,
  input  logic              ext1_n,
  input  logic              ext2_n,
  input  logic              ext3_n,
  input  logic              pwr_absent,
  input  logic              batt_good,
  input  logic              media_pin,
  input  logic              codec_req,
  input  logic              tmr1_req,
  input  logic              tmr2_req,
  input  logic              rtc_req,
  input  logic              utx_req,
  input  logic              urx_req,
  input  logic              ums_req,
  input  logic              ssi_req,
  input  logic              rd_en,
  input  logic              eoi_batt,
  input  logic              eoi_tick,
  input  logic              eoi_media,
  input  logic              eoi_codec,
  input  logic [NFIQ-1:0]   fiq_mask,
  output logic [STAT_W-1:0] rd_data,
  output logic              fiq
);
  logic [NPIN-1:0]   pin_raw, pin_s;
  logic [NFLT-1:0]   flt_in, flt_q;
  logic              batt_filt, med_filt;
  logic              med_prev_q, med_prev_nxt, med_rise;
  logic [NLAT-1:0]   lat_set, lat_clr, lat_kill, lat_q;
  logic [STAT_W-1:0] stat_w;
  logic [STAT_W-1:0] rd_q, rd_nxt;

  assign pin_raw = {media_pin, batt_good, pwr_absent, ext3_n, ext2_n, ext1_n, fast_n};

  irq_sync #(.W(NPIN), .RST(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  always_comb begin
    flt_in         = '0;
    flt_in[F_BATT] = pin_s[P_PWR] & ~pin_s[P_BOK];
    flt_in[F_MED]  = pin_s[P_MED];
  end

  irq_deglitch #(.W(NFLT)) u_dg (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .d(flt_in), .q(flt_q)
  );

  assign batt_filt = flt_q[F_BATT];
  assign med_filt  = flt_q[F_MED];

  // media edge detector on the filtered level
  always_comb begin
    med_prev_nxt = med_filt;
    med_rise     = med_filt & ~med_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) med_prev_q <= 1'b0;
    else        med_prev_q <= med_prev_nxt;
  end

  always_comb begin
    lat_set           = '0;
    lat_clr           = '0;
    lat_kill          = '0;
    lat_set[L_BATT]   = batt_filt;
    lat_set[L_WDOG]   = tick_en & lat_q[L_TICK];
    lat_set[L_MEDIA]  = med_rise;
    lat_set[L_CODEC]  = codec_req;
    lat_set[L_TICK]   = tick_en;
    lat_clr[L_BATT]   = eoi_batt;
    lat_clr[L_WDOG]   = eoi_tick;
    lat_clr[L_MEDIA]  = eoi_media;
    lat_clr[L_CODEC]  = eoi_codec;
    lat_clr[L_TICK]   = eoi_tick;
    lat_kill[L_BATT]  = standby;
    lat_kill[L_WDOG]  = standby;
  end

  irq_flag_bank #(.N(NLAT)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(lat_set), .clr(lat_clr),
    .kill(lat_kill), .q(lat_q)
  );

  always_comb begin
    stat_w          = '0;
    stat_w[B_FAST]  = ~pin_s[P_FAST];
    stat_w[B_BATT]  = lat_q[L_BATT];
    stat_w[B_WDOG]  = lat_q[L_WDOG];
    stat_w[B_MEDIA] = lat_q[L_MEDIA];
    stat_w[B_CODEC] = lat_q[L_CODEC];
    stat_w[B_EXT1]  = ~pin_s[P_EXT1];
    stat_w[B_EXT2]  = ~pin_s[P_EXT2];
    stat_w[B_EXT3]  = ~pin_s[P_EXT3];
    stat_w[B_TMR1]  = tmr1_req;
    stat_w[B_TMR2]  = tmr2_req;
    stat_w[B_RTC]   = rtc_req;
    stat_w[B_TICK]  = lat_q[L_TICK];
    stat_w[B_UTX]   = utx_req;
    stat_w[B_URX]   = urx_req;
    stat_w[B_UMS]   = ums_req;
    stat_w[B_SSI]   = ssi_req;
  end

  assign fiq = |(stat_w[NFIQ-1:0] & fiq_mask);

  always_comb begin
    rd_nxt = rd_en ? stat_w : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              tick_en,
  input logic              eoi_tick,
  input logic              eoi_batt,
  input logic              eoi_codec,
  input logic              rd_en,
  input logic              batt_filt,
  input logic [STAT_W-1:0] stat,
  input logic [NFIQ-1:0]   fiq_mask,
  input logic              fiq,
  input logic [STAT_W-1:0] rd_data
);
  // R7
  wdog_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !stat[B_WDOG]);

  // R6
  tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> stat[B_TICK]);

  // R9
  eoi_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && eoi_tick) |=> stat[B_TICK]);

  // R8
  codec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[B_CODEC] && !eoi_codec) |=> stat[B_CODEC]);

  // R4
  batt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_batt && !batt_filt) |=> !stat[B_BATT]);

  // R10
  fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_mask == '0) |-> !fiq);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));

  // R11
  rd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data == $past(stat)));
endmodule

bind irq_status_unit irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .tick_en(tick_en),
  .eoi_tick(eoi_tick), .eoi_batt(eoi_batt), .eoi_codec(eoi_codec),
  .rd_en(rd_en), .batt_filt(batt_filt), .stat(stat_w),
  .fiq_mask(fiq_mask), .fiq(fiq), .rd_data(rd_data)
);

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic smp_en, tick_en, standby;
  logic fast_n, ext1_n, ext2_n, ext3_n, pwr_absent, batt_good, media_pin;
  logic codec_req, tmr1_req, tmr2_req, rtc_req, utx_req, urx_req, ums_req, ssi_req;
  logic rd_en, eoi_batt, eoi_tick, eoi_media, eoi_codec;
  logic [3:0]  fiq_mask;
  logic [15:0] rd_data;
  logic        fiq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .tick_en(tick_en), .standby(standby),
    .fast_n(fast_n), .ext1_n(ext1_n), .ext2_n(ext2_n), .ext3_n(ext3_n),
    .pwr_absent(pwr_absent), .batt_good(batt_good), .media_pin(media_pin),
    .codec_req(codec_req), .tmr1_req(tmr1_req), .tmr2_req(tmr2_req), .rtc_req(rtc_req),
    .utx_req(utx_req), .urx_req(urx_req), .ums_req(ums_req), .ssi_req(ssi_req),
    .rd_en(rd_en), .eoi_batt(eoi_batt), .eoi_tick(eoi_tick), .eoi_media(eoi_media),
    .eoi_codec(eoi_codec), .fiq_mask(fiq_mask), .rd_data(rd_data), .fiq(fiq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(output logic [15:0] v);
    rd_en = 1'b1;
    step(1);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic smp(input int n);
    for (int i = 0; i < n; i++) begin
      smp_en = 1'b1; step(1); smp_en = 1'b0; step(1);
    end
  endtask

  function automatic logic [15:0] exp_level(input logic [3:0] pins_n, input logic [6:0] req);
    logic [15:0] e;
    e = '0;
    e[0]  = ~pins_n[0];
    e[5]  = ~pins_n[1];
    e[6]  = ~pins_n[2];
    e[7]  = ~pins_n[3];
    e[8]  = req[0];
    e[9]  = req[1];
    e[10] = req[2];
    e[12] = req[3];
    e[13] = req[4];
    e[14] = req[5];
    e[15] = req[6];
    return e;
  endfunction

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    step(200000 - 10);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_up();
  end

  initial begin
    logic [15:0] v;
    logic [3:0]  pins;
    logic [6:0]  req;
    logic [15:0] e;
    int unused_seed;
    unused_seed = $urandom(32'h1d5e);
    rst_n = 1'b0;
    {smp_en, tick_en, standby} = '0;
    {fast_n, ext1_n, ext2_n, ext3_n} = 4'hf;
    pwr_absent = 1'b0; batt_good = 1'b1; media_pin = 1'b0;
    {codec_req, tmr1_req, tmr2_req, rtc_req, utx_req, urx_req, ums_req, ssi_req} = '0;
    {rd_en, eoi_batt, eoi_tick, eoi_media, eoi_codec} = '0;
    fiq_mask = 4'hf;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R12 reset state
    chk("R12 fiq", {15'd0, fiq}, 16'h0);
    rd(v); chk("R12 status", v, 16'h0);
    step(1);
    // R11 idle read port
    chk("R11 idle", rd_data, 16'h0);

    // R1 R2 R10 random level sources
    for (int it = 0; it < 150; it++) begin
      pins = 4'($urandom);
      req  = 7'($urandom);
      fiq_mask = 4'($urandom);
      {ext3_n, ext2_n, ext1_n, fast_n} = pins;
      {ssi_req, ums_req, urx_req, utx_req, rtc_req, tmr2_req, tmr1_req} = req;
      step(3);
      e = exp_level(pins, req);
      chk("R10 fiq", {15'd0, fiq}, {15'd0, ~pins[0] & fiq_mask[0]});
      rd(v); chk("R1/R2 status", v, e);
    end
    {fast_n, ext1_n, ext2_n, ext3_n} = 4'hf;
    {tmr1_req, tmr2_req, rtc_req, utx_req, urx_req, ums_req, ssi_req} = '0;
    fiq_mask = 4'hf;
    step(3);

    // R1 no strobe clears a pin-level bit
    ext1_n = 1'b0; step(3);
    {eoi_batt, eoi_tick, eoi_media, eoi_codec} = 4'hf; step(1);
    {eoi_batt, eoi_tick, eoi_media, eoi_codec} = 4'h0; step(1);
    rd(v); chk("R1 ext1 held", v, 16'h0020);
    ext1_n = 1'b1; step(3);
    rd(v); chk("R1 ext1 release", v, 16'h0000);

    // R3 single-sample pulse rejected
    pwr_absent = 1'b1; batt_good = 1'b0; step(3);
    smp(1);
    pwr_absent = 1'b0; batt_good = 1'b1; step(3);
    smp(3);
    rd(v); chk("R3 glitch", v, 16'h0000);

    // R3 two samples accept
    pwr_absent = 1'b1; batt_good = 1'b0; step(3);
    smp(1);
    rd(v); chk("R3 one sample", v, 16'h0000);
    smp(1); step(1);
    rd(v); chk("R3 battery low", v, 16'h0002);
    // R10 mask selection
    fiq_mask = 4'b1101; step(1);
    chk("R10 masked", {15'd0, fiq}, 16'h0);
    fiq_mask = 4'b0010; step(1);
    chk("R10 enabled", {15'd0, fiq}, 16'h1);
    fiq_mask = 4'hf;

    // R4 eoi ineffective while condition holds, then clears
    eoi_batt = 1'b1; step(1); eoi_batt = 1'b0; step(1);
    rd(v); chk("R4 still set", v, 16'h0002);
    // R4 standby forces inactive
    standby = 1'b1; step(2);
    rd(v); chk("R4 standby", v, 16'h0000);
    standby = 1'b0; step(2);
    pwr_absent = 1'b0; batt_good = 1'b1; step(3);
    smp(2); step(1);
    rd(v); chk("R4 latched", v, 16'h0002);
    eoi_batt = 1'b1; step(1); eoi_batt = 1'b0; step(1);
    rd(v); chk("R4 cleared", v, 16'h0000);

    // R5 media edge latched
    media_pin = 1'b1; step(3);
    smp(2); step(2);
    rd(v); chk("R5 media set", v, 16'h0008);
    media_pin = 1'b0; step(3);
    smp(2); step(1);
    rd(v); chk("R5 media held", v, 16'h0008);
    eoi_media = 1'b1; step(1); eoi_media = 1'b0; step(1);
    rd(v); chk("R5 media clear", v, 16'h0000);

    // R6 R7 tick and watchdog
    tick_en = 1'b1; step(1); tick_en = 1'b0;
    rd(v); chk("R6 tick set", v, 16'h0800);
    chk("R7 no fiq yet", {15'd0, fiq}, 16'h0);
    tick_en = 1'b1; step(1); tick_en = 1'b0;
    rd(v); chk("R7 watchdog", v, 16'h0804);
    chk("R10 wdog fiq", {15'd0, fiq}, 16'h1);
    eoi_tick = 1'b1; step(1); eoi_tick = 1'b0;
    rd(v); chk("R6 tick clear", v, 16'h0000);

    // R9 set and eoi in the same cycle
    tick_en = 1'b1; step(1); tick_en = 1'b0;
    tick_en = 1'b1; eoi_tick = 1'b1; step(1); tick_en = 1'b0; eoi_tick = 1'b0;
    rd(v); chk("R9 tick race", v, 16'h0804);
    // R7 standby clears watchdog
    standby = 1'b1; step(1); standby = 1'b0;
    rd(v); chk("R7 standby", v, 16'h0800);
    eoi_tick = 1'b1; step(1); eoi_tick = 1'b0;
    rd(v); chk("R6 clear", v, 16'h0000);

    // R8 codec latch
    codec_req = 1'b1; step(1); codec_req = 1'b0; step(2);
    rd(v); chk("R8 codec held", v, 16'h0010);
    codec_req = 1'b1; eoi_codec = 1'b1; step(1); codec_req = 1'b0; eoi_codec = 1'b0;
    rd(v); chk("R9 codec race", v, 16'h0010);
    eoi_codec = 1'b1; step(1); eoi_codec = 1'b0;
    rd(v); chk("R8 codec clear", v, 16'h0000);

    finish_up();
  end
endmodule